// File: doc/BRIEF.md
# Retriggerable Clocked One-Shot

This block is a single-channel, clock-driven pulse generator that behaves like a precision monostable. A down-counter takes the place of a resistor-capacitor timing network. The pulse length is a programmable number of clock cycles. The block has two trigger inputs. One fires on a rising edge and is enabled only while the other input is high. The other fires on a falling edge and is enabled only while the first input is low. An active-low clear ends a running pulse and blocks new triggers for as long as it is held low. The output pulse is provided in both true and inverted form.

The three control inputs are asynchronous, so each passes through a two-flop synchronizer, and edges are found on the synchronized copies. A valid trigger loads the programmed width and drives the pulse high. In the default mode, a trigger that arrives while the pulse is high reloads the width, so the pulse ends one full width after the last accepted trigger. A mode input can instead make the block ignore triggers while the pulse is high. The width input and the mode input are configuration, and they are meant to be held steady while triggers are applied.

Top module: `oneshot_pulse`

## Requirements
- R1: After reset, and whenever no pulse is running, `pulse_o` is 0 and `pulse_n_o` is 1.
- R2: A 0-to-1 change on `trig_rise_i` counts as a valid trigger only while `trig_fall_i` is 1 and `clr_n_i` is 1.
- R3: A 1-to-0 change on `trig_fall_i` counts as a valid trigger only while `trig_rise_i` is 0 and `clr_n_i` is 1.
- R4: From idle, a valid trigger makes `pulse_o` go high at the third rising clock edge after the input changes: two synchronizer stages, then the output register.
- R5: A pulse that is not disturbed stays high for exactly N cycles. N is the value of `width_i` at the trigger. A width of 0 is treated as 1.
- R6: With `no_retrig_i`=0, a valid trigger while `pulse_o` is high reloads the count, so `pulse_o` stays high until N cycles after the last trigger. A trigger on the cycle the count expires wins, and the output does not drop.
- R7: With `no_retrig_i`=1, valid triggers that arrive while `pulse_o` is high have no effect on the pulse length. A trigger on the cycle the count expires is also ignored.
- R8: When `clr_n_i` goes to 0, `pulse_o` goes low at the third rising clock edge after the change, even if the programmed width has not elapsed.
- R9: While `clr_n_i` is 0, no trigger edge starts a pulse. Once `clr_n_i` is back at 1, triggers work normally.
- R10: `pulse_n_o` is always the inverse of `pulse_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trig_rise_i | input | 1 | Trigger input that acts on its rising edge (asynchronous) |
| trig_fall_i | input | 1 | Trigger input that acts on its falling edge (asynchronous) |
| clr_n_i | input | 1 | Active-low clear (asynchronous) |
| no_retrig_i | input | 1 | 1 = ignore triggers while the pulse is high |
| width_i | input | CNT_W | Pulse width in clock cycles, sampled at each accepted trigger |
| pulse_o | output | 1 | Pulse output, high while timing |
| pulse_n_o | output | 1 | Inverse of pulse_o |

## Verification
The assertions assume that `width_i` and `no_retrig_i` hold steady while a pulse can start or is running. They also assume that each trigger input holds its level for at least one full clock cycle, so that the synchronizer samples every change. The bench changes the width and the mode only while the block is idle. It drives every trigger and clear change on the falling clock edge and holds each level for at least one cycle. It puts the gating input into its blocking level while the clear is low, so that this setup step cannot itself produce a valid edge.

// File: rtl/oneshot_pkg.sv
`timescale 1ns/1ps
package oneshot_pkg;
  localparam int unsigned SYNC_DEPTH = 2;

  typedef struct packed {
    logic rise_in;
    logic fall_in;
    logic clr_n;
  } ctl_t;

  // Reset level chosen so that no edge seen after reset can qualify.
  localparam ctl_t CTL_SAFE = '{rise_in: 1'b1, fall_in: 1'b0, clr_n: 1'b0};
endpackage

// File: rtl/oneshot_rstsync.sv
`timescale 1ns/1ps
module oneshot_rstsync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [DEPTH-1:0] chain_q;
  logic [DEPTH-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[DEPTH-1];
endmodule

// File: rtl/oneshot_sync.sv
`timescale 1ns/1ps
module oneshot_sync #(
  parameter int unsigned     DEPTH   = 2,
  parameter int unsigned     W       = 3,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [DEPTH];
  logic [W-1:0] stg_d [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_stage
    if (gi == 0) begin : g_first
      always_comb stg_d[gi] = d_i;
    end else begin : g_next
      always_comb stg_d[gi] = stg_q[gi-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[gi] <= RST_VAL;
      else        stg_q[gi] <= stg_d[gi];
    end
  end

  assign q_o = stg_q[DEPTH-1];
endmodule

// File: rtl/oneshot_qual.sv
`timescale 1ns/1ps
module oneshot_qual
  import oneshot_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  ctl_t sync_i,
  output logic trig_o,
  output logic clr_ok_o
);
  ctl_t prev_q;
  logic rise_v;
  logic fall_v;

  always_comb begin
    rise_v = sync_i.rise_in & ~prev_q.rise_in & sync_i.fall_in & sync_i.clr_n;
    fall_v = ~sync_i.fall_in & prev_q.fall_in & ~sync_i.rise_in & sync_i.clr_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= CTL_SAFE;
    else        prev_q <= sync_i;
  end

  assign trig_o   = rise_v | fall_v;
  assign clr_ok_o = sync_i.clr_n;

  // R2
  // R3
  trig_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_v, fall_v}));

  // R9
  clr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_ok_o |-> !trig_o);
endmodule

// File: rtl/oneshot_timer.sv
`timescale 1ns/1ps
module oneshot_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_i,
  input  logic          clr_ok_i,
  input  logic          no_retrig_i,
  input  logic [CW-1:0] width_i,
  output logic          pulse_o
);
  logic          q_q, q_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          accept;
  logic          upd_en;
  logic [CW-1:0] load_val;

  always_comb begin
    accept   = trig_i & ~(no_retrig_i & q_q);
    load_val = (width_i == '0) ? CW'(1) : width_i;
    upd_en   = ~clr_ok_i | accept | q_q;
    q_d      = q_q;
    cnt_d    = cnt_q;
    if (!clr_ok_i) begin
      q_d   = 1'b0;
      cnt_d = '0;
    end else if (accept) begin
      q_d   = 1'b1;
      cnt_d = load_val;
    end else if (q_q) begin
      if (cnt_q <= CW'(1)) begin
        q_d   = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q - CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q   <= 1'b0;
      cnt_q <= '0;
    end else if (upd_en) begin
      q_q   <= q_d;
      cnt_q <= cnt_d;
    end
  end

  assign pulse_o = q_q;

  // R8
  clr_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_ok_i |=> !q_q);

  // R4
  trig_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_i && clr_ok_i && !q_q |=> q_q);

  // R6
  retrig_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_i && clr_ok_i && q_q && !no_retrig_i |=>
      q_q && cnt_q == (($past(width_i) == '0) ? CW'(1) : $past(width_i)));

  // R7
  retrig_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_i && clr_ok_i && q_q && no_retrig_i && cnt_q > CW'(1) |=>
      cnt_q == $past(cnt_q) - CW'(1));

  // R5
  width_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_q && cnt_q > CW'(1) && clr_ok_i |=> q_q);

  // R5
  width_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_q && cnt_q == CW'(1) && !trig_i |=> !q_q);
endmodule

// File: rtl/oneshot_pulse.sv
`timescale 1ns/1ps
module oneshot_pulse
  import oneshot_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_rise_i,
  input  logic             trig_fall_i,
  input  logic             clr_n_i,
  input  logic             no_retrig_i,
  input  logic [CNT_W-1:0] width_i,
  output logic             pulse_o,
  output logic             pulse_n_o
);
  localparam int unsigned CTL_W = $bits(ctl_t);

  logic rst_n_s;
  ctl_t raw_ctl;
  ctl_t sync_ctl;
  logic trig;
  logic clr_ok;
  logic pulse;

  always_comb begin
    raw_ctl.rise_in = trig_rise_i;
    raw_ctl.fall_in = trig_fall_i;
    raw_ctl.clr_n   = clr_n_i;
  end

  oneshot_rstsync #(.DEPTH(SYNC_DEPTH)) u_rstsync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_n_s)
  );

  oneshot_sync #(
    .DEPTH   (SYNC_DEPTH),
    .W       (CTL_W),
    .RST_VAL (CTL_SAFE)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n_s),
    .d_i   (raw_ctl),
    .q_o   (sync_ctl)
  );

  oneshot_qual u_qual (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .sync_i   (sync_ctl),
    .trig_o   (trig),
    .clr_ok_o (clr_ok)
  );

  oneshot_timer #(.CW(CNT_W)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .trig_i      (trig),
    .clr_ok_i    (clr_ok),
    .no_retrig_i (no_retrig_i),
    .width_i     (width_i),
    .pulse_o     (pulse)
  );

  assign pulse_o   = pulse;
  assign pulse_n_o = ~pulse;
endmodule

// File: tb/oneshot_pulse_bench.sv
`timescale 1ns/1ps
module oneshot_pulse_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       a, b, clr, md;
  logic [7:0] w;
  logic       pulse_o, pulse_n_o;
  int         checks = 0;
  int         fails  = 0;
  int         comp_bad = 0;

  always #4 clk = ~clk;

  oneshot_pulse #(.CNT_W(8)) u_oneshot_pulse (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig_rise_i (a),
    .trig_fall_i (b),
    .clr_n_i     (clr),
    .no_retrig_i (md),
    .width_i     (w),
    .pulse_o     (pulse_o),
    .pulse_n_o   (pulse_n_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Samples at the falling edge; also tracks the R10 complement rule.
  function automatic bit samp();
    if (pulse_n_o !== ~pulse_o) comp_bad++;
    return pulse_o;
  endfunction

  task automatic fire(input bit src);
    if (src) b = 1'b0; else a = 1'b1;
  endtask

  task automatic unfire();
    a = 1'b0;
    b = 1'b1;
  endtask

  // Trigger at k=0 and again at k=d; compare every sample with the
  // arithmetic expectation (R4 latency 3, width n, R6/R7 rules).
  task automatic run_pair(input int wv, input int n, input bit mode,
                          input bit src, input int d, input string tag);
    int bad = 0;
    w  = 8'(wv);
    md = mode;
    for (int k = 0; k <= d + n + 8; k++) begin
      bit got, in1, in2, exp;
      @(negedge clk);
      got = samp();
      in1 = (k >= 3) && (k < 3 + n);
      in2 = (k >= 3 + d) && (k < 3 + d + n);
      exp = in1 || (in2 && (!mode || d > n));
      if (got != exp) bad++;
      if (k == 0 || k == d) fire(src); else unfire();
    end
    chk(bad == 0, $sformatf("%s n=%0d mode=%0d src=%0d d=%0d mismatches", tag, n, mode, src, d),
        bad, 0);
  endtask

  task automatic count_high(input int cyc, output int highs);
    highs = 0;
    for (int k = 0; k < cyc; k++) begin
      @(negedge clk);
      if (samp()) highs++;
    end
  endtask

  initial begin
    #1_600_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int highs;
    rst_n = 1'b0;
    a = 1'b0; b = 1'b1; clr = 1'b1; md = 1'b0; w = 8'd4;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    count_high(8, highs);
    // R1: idle after reset
    chk(pulse_o == 1'b0, "R1 idle pulse_o", int'(pulse_o), 0);
    chk(pulse_n_o == 1'b1, "R1 idle pulse_n_o", int'(pulse_n_o), 1);
    chk(highs == 0, "R1 no pulse after reset", highs, 0);

    // Sweep: widths 1..5, both modes, both trigger inputs (R2, R3 valid
    // paths), second trigger offset up to width+2, including the cycle
    // where the count expires (R6 priority, R7 ignore).
    for (int n = 1; n <= 5; n++)
      for (int mode = 0; mode < 2; mode++)
        for (int src = 0; src < 2; src++)
          for (int d = 2; d <= n + 2; d++)
            run_pair(n, n, mode[0], src[0], d, mode ? "R7 R5 R4" : "R6 R5 R4");

    // R5: width 0 behaves as 1
    run_pair(0, 1, 1'b0, 1'b0, 4, "R5 zero width");
    run_pair(0, 1, 1'b0, 1'b1, 4, "R5 zero width");

    // R2: rising edge while the other input is low is not a trigger
    clr = 1'b0; count_high(4, highs);
    b = 1'b0;   count_high(4, highs);
    clr = 1'b1; count_high(5, highs);
    a = 1'b1;   count_high(1, highs);
    a = 1'b0;   count_high(10, highs);
    chk(highs == 0, "R2 rise gated by low fall input", highs, 0);
    b = 1'b1;   count_high(6, highs);
    chk(highs == 0, "R2 rising fall input is no trigger", highs, 0);

    // R3: falling edge while the other input is high is not a trigger
    clr = 1'b0; count_high(4, highs);
    a = 1'b1;   count_high(4, highs);
    clr = 1'b1; count_high(5, highs);
    b = 1'b0;   count_high(1, highs);
    b = 1'b1;   count_high(10, highs);
    chk(highs == 0, "R3 fall gated by high rise input", highs, 0);
    a = 1'b0;   count_high(6, highs);
    chk(highs == 0, "R3 falling rise input is no trigger", highs, 0);

    // R8: clear cuts a width-8 pulse: high for samples 3..6 only
    begin
      int bad = 0;
      w = 8'd8; md = 1'b0;
      for (int k = 0; k <= 14; k++) begin
        bit exp;
        @(negedge clk);
        exp = (k >= 3) && (k < 7);
        if (samp() != exp) bad++;
        if (k == 0) a = 1'b1;
        if (k == 1) a = 1'b0;
        if (k == 4) clr = 1'b0;
      end
      chk(bad == 0, "R8 clear shortens pulse", bad, 0);
    end

    // R9: triggers while clear is low do nothing
    fire(1'b0); count_high(1, highs); unfire(); count_high(3, highs);
    fire(1'b1); count_high(1, highs); unfire(); count_high(10, highs);
    chk(highs == 0, "R9 triggers blocked by clear", highs, 0);
    clr = 1'b1;
    count_high(5, highs);
    chk(highs == 0, "R9 release alone starts nothing", highs, 0);
    run_pair(3, 3, 1'b0, 1'b0, 9, "R9 after release");

    // R10: complement held on every sample taken
    chk(comp_bad == 0, "R10 pulse_n_o complement", comp_bad, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule